// File: doc/BRIEF.md
# Operand Alignment and Add/Subtract Stage with Guard, Round and Sticky

This block is the front half of a floating-point adder. It receives two significands, of which `x` belongs to the operand with the larger (or equal) exponent, together with the exponent difference. It shifts the `y` significand right by that difference. Two positions below the LSB are kept as a guard bit and a round bit. Every bit pushed past the round position is collapsed into a single sticky bit. It then adds or subtracts the extended significands. The sticky bit takes part as the lowest bit, so a subtraction borrows exactly as it would with the full-width shifted operand.

The raw sum is normalized by at most one place, either right after a carry or left after a single cancelled leading bit. The block reports the W-bit significand, a round bit and a sticky bit, already placed for the final rounding step. It also reports the result sign and a two-bit code that the exponent path uses for its adjustment. Results are registered and tagged with a valid bit one cycle after the request.

Top module: `align_grs_adder`

## Requirements
- R1: `o_valid` is 0 during reset. One cycle after each clock edge, `o_valid` equals the `in_valid` value sampled at that edge.
- R2: The operation is a subtraction when `x_sign ^ y_sign ^ op_sub` is 1, and an addition otherwise.
- R3: `y_sig` is shifted right by `shamt`. Any 1 shifted below the round position sets the sticky information. A `shamt` of SIG_W+2 or more moves the whole of `y_sig` into sticky, and its aligned value becomes zero.
- R4: If an addition carries out of the top bit, `o_shift` is 2'b10 and the significand is taken one place higher. `o_rnd` is the previous LSB, and `o_stk` is the OR of the guard, round and sticky bits.
- R5: If the MSB of the result is already set, `o_shift` is 2'b00. `o_rnd` is the guard bit, and `o_stk` is the OR of the round and sticky bits.
- R6: Otherwise `o_shift` is 2'b01. The guard bit moves into the LSB, the round bit becomes `o_rnd`, and the sticky bit becomes `o_stk`.
- R7: With a normalized `x_sig` (MSB set), a subtraction with `shamt` of 2 or more always yields a result with `o_sig[SIG_W-1]` set.
- R8: A subtraction with `shamt` 0 and `y_sig` > `x_sig` returns the magnitude of the difference with `o_sign` = `!x_sign`. In every other case `o_sign` equals `x_sign`, and a zero result also carries `x_sign`.
- R9: While `in_valid` is 0, all data outputs keep their values.
- R10: For a normalized `x_sig`, `{o_sig, o_rnd, o_stk}` equals the exact result truncated at the rounding position, with the sticky bit set to the OR of all exact bits below the round bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| x_sign | input | 1 | Sign of larger-exponent operand |
| y_sign | input | 1 | Sign of smaller-exponent operand |
| op_sub | input | 1 | 1 requests x - y, 0 requests x + y |
| x_sig | input | SIG_W | Larger-exponent significand (minuend) |
| y_sig | input | SIG_W | Smaller-exponent significand |
| shamt | input | SH_W | Exponent difference |
| o_valid | output | 1 | Result valid |
| o_sign | output | 1 | Result sign |
| o_sig | output | SIG_W | Normalized significand |
| o_rnd | output | 1 | Round bit after normalization |
| o_stk | output | 1 | Sticky bit after normalization |
| o_shift | output | 2 | 00 none, 01 left one place, 10 right one place |

## Verification
Every result field is due exactly one rising edge after the inputs are presented with `in_valid` high. The bench drives a new vector each cycle just after an edge. It samples all outputs shortly after the following edge, well before the next one. The expected values come from exact integer arithmetic on the unshifted operands. For a cycle with `in_valid` low, the bench compares the outputs one edge later with the values captured from the previous result.

// File: rtl/align_grs_adder.sv
module align_grs_adder #(
  parameter int SIG_W = 24,
  parameter int SH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             x_sign,
  input  logic             y_sign,
  input  logic             op_sub,
  input  logic [SIG_W-1:0] x_sig,
  input  logic [SIG_W-1:0] y_sig,
  input  logic [SH_W-1:0]  shamt,
  output logic             o_valid,
  output logic             o_sign,
  output logic [SIG_W-1:0] o_sig,
  output logic             o_rnd,
  output logic             o_stk,
  output logic [1:0]       o_shift
);
  localparam int EW = SIG_W + 2;
  localparam int XW = SIG_W + 3;
  localparam int AW = SIG_W + 4;
  localparam logic [1:0] SH_NONE  = 2'b00;
  localparam logic [1:0] SH_LEFT  = 2'b01;
  localparam logic [1:0] SH_RIGHT = 2'b10;

  logic          eff_sub;
  logic [EW-1:0] y_ext, y_shr;
  logic          y_stk;
  logic [XW-1:0] minu, aligned;
  logic [AW-1:0] raw, mag;
  logic          neg;
  logic [SIG_W-1:0] n_sig;
  logic          n_rnd, n_stk;
  logic [1:0]    n_shift;

  assign eff_sub = x_sign ^ y_sign ^ op_sub;
  assign y_ext   = {y_sig, 2'b00};

  always_comb begin
    int sh_i;
    sh_i  = int'(shamt);
    y_stk = 1'b0;
    for (int i = 0; i < EW; i++)
      if (i < sh_i) y_stk = y_stk | y_ext[i];
    y_shr = (sh_i >= EW) ? '0 : (y_ext >> sh_i);
  end

  assign minu    = {x_sig, 3'b000};
  assign aligned = {y_shr, y_stk};
  assign raw     = eff_sub ? ({1'b0, minu} - {1'b0, aligned})
                           : ({1'b0, minu} + {1'b0, aligned});
  assign neg     = eff_sub & raw[AW-1];
  assign mag     = neg ? (~raw + AW'(1)) : raw;

  always_comb begin
    if (!eff_sub && mag[AW-1]) begin
      n_shift = SH_RIGHT;
      n_sig   = mag[AW-1:4];
      n_rnd   = mag[3];
      n_stk   = |mag[2:0];
    end else if (mag[AW-2]) begin
      n_shift = SH_NONE;
      n_sig   = mag[AW-2:3];
      n_rnd   = mag[2];
      n_stk   = |mag[1:0];
    end else begin
      n_shift = SH_LEFT;
      n_sig   = mag[AW-3:2];
      n_rnd   = mag[1];
      n_stk   = mag[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_sign  <= 1'b0;
      o_sig   <= '0;
      o_rnd   <= 1'b0;
      o_stk   <= 1'b0;
      o_shift <= SH_NONE;
    end else begin
      o_valid <= in_valid;
      if (in_valid) begin
        o_sign  <= x_sign ^ neg;
        o_sig   <= n_sig;
        o_rnd   <= n_rnd;
        o_stk   <= n_stk;
        o_shift <= n_shift;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> o_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !o_valid); // R1
  AST_HOLD_SIG: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(o_sig) && $stable(o_shift)); // R9
  AST_ADD_NO_LEFT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !eff_sub && x_sig[SIG_W-1]) |=> o_shift != SH_LEFT); // R4
  AST_SUB_NO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && eff_sub) |=> o_shift != SH_RIGHT); // R2
  AST_FAR_SUB_NORM: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && eff_sub && x_sig[SIG_W-1] && shamt >= SH_W'(2)) |=> o_sig[SIG_W-1]); // R7
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && shamt != '0 && x_sig[SIG_W-1]) |=> o_sign == $past(x_sign)); // R8
endmodule

// File: tb/tb_align_grs_adder.sv
module tb_align_grs_adder;
  localparam int W = 6;
  localparam int SH = 4;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, x_sign = 0, y_sign = 0, op_sub = 0;
  logic [W-1:0] x_sig = '0, y_sig = '0;
  logic [SH-1:0] shamt = '0;
  logic o_valid, o_sign, o_rnd, o_stk;
  logic [W-1:0] o_sig;
  logic [1:0] o_shift;
  int n_cmp = 0, n_bad = 0;

  align_grs_adder #(.SIG_W(W), .SH_W(SH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_sign(x_sign), .y_sign(y_sign),
    .op_sub(op_sub), .x_sig(x_sig), .y_sig(y_sig), .shamt(shamt), .o_valid(o_valid),
    .o_sign(o_sign), .o_sig(o_sig), .o_rnd(o_rnd), .o_stk(o_stk), .o_shift(o_shift));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (x=%0d y=%0d sh=%0d)", tag, got, exp, x_sig, y_sig, shamt);
    end
  endtask

  task automatic run_vec(input logic xs, input logic ys, input logic op,
                         input int xv, input int yv, input int sh);
    longint a, r, mag, one;
    logic neg, eff;
    int k, p;
    longint e_sig, e_rnd, e_stk;
    logic [1:0] e_code;
    x_sign = xs; y_sign = ys; op_sub = op;
    x_sig = W'(xv); y_sig = W'(yv); shamt = SH'(sh); in_valid = 1;
    one = 64'd1;
    a = longint'(xv) << sh;
    eff = xs ^ ys ^ op;
    r = eff ? a - longint'(yv) : a + longint'(yv);
    neg = (r < 0);
    mag = neg ? -r : r;
    if (mag >= (one << (W + sh))) begin k = 1; e_code = 2'b10; end
    else if (mag >= (one << (W - 1 + sh))) begin k = 0; e_code = 2'b00; end
    else begin k = -1; e_code = 2'b01; end
    p = sh + k;
    if (p >= 0) e_sig = (mag >> p) & ((one << W) - 1);
    else e_sig = (mag << 1) & ((one << W) - 1);
    e_rnd = (p >= 1) ? ((mag >> (p - 1)) & 1) : 0;
    e_stk = (p >= 2) ? longint'((mag & ((one << (p - 1)) - 1)) != 0) : 0;
    @(posedge clk); #1;
    chk("R1 valid", o_valid, 1);
    chk(neg ? "R8 swapped sign" : "R2 sign", o_sign, xs ^ neg);
    chk(k == 1 ? "R4 code" : (k == 0 ? "R5 code" : "R6 code"), o_shift, e_code);
    chk(sh >= W + 2 ? "R3 far sig" : "R10 sig", o_sig, e_sig);
    chk(k == 1 ? "R4 rnd" : (k == 0 ? "R5 rnd" : "R6 rnd"), o_rnd, e_rnd);
    chk(sh >= 2 ? "R3 stk" : "R10 stk", o_stk, e_stk);
    if (eff && sh >= 2) chk("R7 msb", o_sig[W-1], 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] keep_sig;
    logic [1:0] keep_code;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", o_valid, 0);
    chk("R1 reset sig", o_sig, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    run_vec(0, 0, 0, 63, 63, 0);
    run_vec(0, 0, 1, 32, 63, 0);
    run_vec(1, 1, 1, 40, 40, 0);
    run_vec(0, 0, 1, 32, 1, 9);
    run_vec(0, 1, 0, 32, 63, 15);
    for (int xv = 32; xv < 64; xv++)
      for (int yv = 0; yv < 64; yv++)
        for (int sh = 0; sh < 16; sh++) begin
          int s;
          s = (xv + yv + sh) % 8;
          run_vec(s[2], s[1], s[0], xv, yv, sh);
        end
    keep_sig = o_sig; keep_code = o_shift;
    in_valid = 0; x_sig = 6'd33; y_sig = 6'd17; shamt = 4'd3; op_sub = ~op_sub;
    @(posedge clk); #1;
    chk("R1 idle valid", o_valid, 0);
    chk("R9 hold sig", o_sig, keep_sig);
    chk("R9 hold code", o_shift, keep_code);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule